// File: doc/BRIEF.md
# Multiplexed CPU Bus Memory Emulator

This block acts as the memory behind an 8-bit microprocessor bus with a 16-bit address. The board has too few input pins for address and data, so four external octal transceivers take turns driving one shared 8-bit lane into the block. The block watches the CPU clock and the read/write line, both brought in through two-flop synchronizers. It then drives four active-low transceiver enables in a fixed order: address high byte, address low byte, then either data-in or data-out. After every enable change it waits a settle time, given as a parameter in system clock cycles, before it samples the lane.

The assembled address indexes a byte memory of 2**MEM_AW entries. The address bits above that are dropped, so the memory repeats across the whole 64 KiB CPU space. A width of 13 gives an 8 KiB memory, and the default of 11 keeps elaboration small. On a CPU read, the byte goes out on two output groups (low bits and high bits). Each group has its own register, and both are loaded on the same edge. On a CPU write, the byte on the lane is stored. A host port lets the system preload the memory and read it back. When the host and the CPU write in the same cycle, the host write is kept.

Top module: `mbus_mem_emu`

## Requirements
- R1: While rst_n is low, all four enables are high (inactive) and both data-out groups are 0. An enable that is active when reset is applied goes inactive at once.
- R2: After a falling edge of the synchronized CPU clock, the address-high enable (ahi_en_n_o) is the only enable driven low.
- R3: Once the settle time has passed and the synchronized CPU clock is high, the lane is captured as the high address byte. The address-low enable then replaces the address-high enable.
- R4: On a write, the address-low enable stays low for exactly SETTLE system cycles before the data-in enable takes over. On a read, it stays low for SETTLE+2 cycles before the data-out enable takes over.
- R5: Only address bits [MEM_AW-1:0] select a memory byte. Addresses that differ only above that bit reach the same byte.
- R6: When read/write is 1 at the end of the low-byte settle, the addressed byte appears as {dout_hi_o, dout_lo_o} with dout_en_n_o low. Both stay unchanged until the next falling CPU clock edge.
- R7: When read/write is 0, the data-in enable goes low. SETTLE cycles later, the lane value is written to the addressed byte.
- R8: At most one of the four enables is low in any cycle.
- R9: dout_lo_o carries data bits [LO_BITS-1:0] and dout_hi_o carries the bits above. The two groups change only on the edge where dout_en_n_o falls, and they change together. A write cycle leaves them unchanged.
- R10: A host write stores host_wdata_i at host_addr_i. host_rdata_o shows the byte at host_addr_i one clock after the address is presented.
- R11: When a host write and a CPU write land on the same edge, the host write is performed and the CPU write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | 1 | CPU bus clock (asynchronous) |
| cpu_rw_i | input | 1 | CPU read (1) / write (0) |
| bus_i | input | 8 | Shared lane from the transceivers |
| ahi_en_n_o | output | 1 | Address-high transceiver enable, active low |
| alo_en_n_o | output | 1 | Address-low transceiver enable, active low |
| din_en_n_o | output | 1 | Data-in transceiver enable, active low |
| dout_en_n_o | output | 1 | Data-out transceiver enable, active low |
| dout_lo_o | output | LO_BITS | Read data, low group |
| dout_hi_o | output | 8-LO_BITS | Read data, high group |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | MEM_AW | Host address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, one cycle latency |

## Verification
The ordering assertions assume the CPU clock phases are long enough for the sequence to finish. The low phase must cover the synchronizer delay plus one settle time. The high phase must cover two settle times plus the read pipeline. The assertions also assume that a falling CPU clock edge never arrives while the block is still sampling.

The stimulus keeps inside these limits. It lowers the CPU clock, waits until the address-high enable shows up, and holds the low phase for several cycles beyond the settle time. It keeps the high phase until the data enable has been observed and the data checked. The bench models the transceivers combinationally from the enables, so the lane only ever carries the source selected by the one enable that is low.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    EN_NONE,
    EN_AHI,
    EN_ALO,
    EN_DIN,
    EN_DOUT
  } en_sel_e;

  typedef enum logic [2:0] {
    ST_WAIT_FALL,
    ST_AHI,
    ST_ALO,
    ST_RD,
    ST_RDO,
    ST_DIN
  } seq_st_e;

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        sync_q <= meta_q;
      end
    end

    assign sync_o[g] = sync_q;
  end

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int SETTLE = 5,
  parameter int MEM_AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_s,
  input  logic              rw_s,
  input  logic [7:0]        bus_i,
  output en_sel_e           en_sel_o,
  output logic [MEM_AW-1:0] cpu_addr_o,
  output logic              cpu_we_o,
  output logic [7:0]        cpu_wdata_o,
  output logic              dout_load_o
);

  localparam int HW = MEM_AW - 8;
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE - 1);

  seq_st_e        st_q, st_d;
  en_sel_e        en_q, en_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [HW-1:0]  hi_q, hi_d;
  logic [7:0]     lo_q, lo_d;
  logic           clk_prev_q;
  logic           cnt_done;
  logic           fall;

  assign cnt_done = (cnt_q == '0);
  assign fall     = clk_prev_q & ~clk_s;

  // next-state process
  always_comb begin
    st_d        = st_q;
    en_d        = en_q;
    cnt_d       = cnt_q;
    hi_d        = hi_q;
    lo_d        = lo_q;
    cpu_we_o    = 1'b0;
    dout_load_o = 1'b0;
    case (st_q)
      ST_WAIT_FALL: begin
        if (fall) begin
          st_d  = ST_AHI;
          en_d  = EN_AHI;
          cnt_d = CNT_LOAD;
        end
      end
      ST_AHI: begin
        if (!cnt_done) begin
          cnt_d = cnt_q - 1'b1;
        end else if (clk_s) begin
          hi_d  = bus_i[HW-1:0];
          en_d  = EN_ALO;
          cnt_d = CNT_LOAD;
          st_d  = ST_ALO;
        end
      end
      ST_ALO: begin
        if (!cnt_done) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          lo_d = bus_i;
          if (rw_s) begin
            st_d = ST_RD;
          end else begin
            st_d  = ST_DIN;
            en_d  = EN_DIN;
            cnt_d = CNT_LOAD;
          end
        end
      end
      ST_RD: begin
        st_d = ST_RDO;
      end
      ST_RDO: begin
        en_d        = EN_DOUT;
        dout_load_o = 1'b1;
        st_d        = ST_WAIT_FALL;
      end
      ST_DIN: begin
        if (!cnt_done) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          cpu_we_o = 1'b1;
          st_d     = ST_WAIT_FALL;
        end
      end
      default: begin
        st_d = ST_WAIT_FALL;
        en_d = EN_NONE;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_WAIT_FALL;
      en_q       <= EN_NONE;
      cnt_q      <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      clk_prev_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      en_q       <= en_d;
      cnt_q      <= cnt_d;
      hi_q       <= hi_d;
      lo_q       <= lo_d;
      clk_prev_q <= clk_s;
    end
  end

  assign en_sel_o    = en_q;
  assign cpu_addr_o  = {hi_q, lo_q};
  assign cpu_wdata_o = bus_i;

endmodule

// File: rtl/mbus_ram.sv
module mbus_ram #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [7:0]    host_wdata_i,
  output logic [7:0]    host_rdata_o,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [7:0]    cpu_wdata_i,
  output logic [7:0]    cpu_rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  // single write port, host first
  always_ff @(posedge clk) begin
    if (host_we_i) begin
      mem_q[host_addr_i] <= host_wdata_i;
    end else if (cpu_we_i) begin
      mem_q[cpu_addr_i] <= cpu_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    host_rdata_o <= mem_q[host_addr_i];
    cpu_rdata_o  <= mem_q[cpu_addr_i];
  end

endmodule

// File: rtl/mbus_mem_emu.sv
module mbus_mem_emu
  import mbus_pkg::*;
#(
  parameter int SETTLE  = 5,
  parameter int MEM_AW  = 11,
  parameter int LO_BITS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_clk_i,
  input  logic                cpu_rw_i,
  input  logic [7:0]          bus_i,
  output logic                ahi_en_n_o,
  output logic                alo_en_n_o,
  output logic                din_en_n_o,
  output logic                dout_en_n_o,
  output logic [LO_BITS-1:0]  dout_lo_o,
  output logic [7-LO_BITS:0]  dout_hi_o,
  input  logic                host_we_i,
  input  logic [MEM_AW-1:0]   host_addr_i,
  input  logic [7:0]          host_wdata_i,
  output logic [7:0]          host_rdata_o
);

  localparam int HI_BITS = 8 - LO_BITS;

  logic [1:0]        sync_vec;
  en_sel_e           en_sel;
  logic [MEM_AW-1:0] cpu_addr;
  logic              cpu_we;
  logic [7:0]        cpu_wdata;
  logic [7:0]        cpu_rdata;
  logic              dout_load;
  logic [LO_BITS-1:0] lo_q;
  logic [HI_BITS-1:0] hi_q;

  mbus_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({cpu_rw_i, cpu_clk_i}),
    .sync_o  (sync_vec)
  );

  mbus_seq #(.SETTLE(SETTLE), .MEM_AW(MEM_AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_s       (sync_vec[0]),
    .rw_s        (sync_vec[1]),
    .bus_i       (bus_i),
    .en_sel_o    (en_sel),
    .cpu_addr_o  (cpu_addr),
    .cpu_we_o    (cpu_we),
    .cpu_wdata_o (cpu_wdata),
    .dout_load_o (dout_load)
  );

  mbus_ram #(.AW(MEM_AW)) u_ram (
    .clk          (clk),
    .host_we_i    (host_we_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .cpu_we_i     (cpu_we),
    .cpu_addr_i   (cpu_addr),
    .cpu_wdata_i  (cpu_wdata),
    .cpu_rdata_o  (cpu_rdata)
  );

  // two output groups, each its own register, one shared load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (dout_load) begin
      lo_q <= cpu_rdata[LO_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (dout_load) begin
      hi_q <= cpu_rdata[7:LO_BITS];
    end
  end

  always_comb begin
    ahi_en_n_o  = (en_sel != EN_AHI);
    alo_en_n_o  = (en_sel != EN_ALO);
    din_en_n_o  = (en_sel != EN_DIN);
    dout_en_n_o = (en_sel != EN_DOUT);
  end

  assign dout_lo_o = lo_q;
  assign dout_hi_o = hi_q;

endmodule

// File: rtl/mbus_mem_emu_chk.sv
module mbus_mem_emu_chk #(
  parameter int LO_BITS = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ahi_en_n_o,
  input logic               alo_en_n_o,
  input logic               din_en_n_o,
  input logic               dout_en_n_o,
  input logic [LO_BITS-1:0] dout_lo_o,
  input logic [7-LO_BITS:0] dout_hi_o
);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (ahi_en_n_o && alo_en_n_o && din_en_n_o && dout_en_n_o));

  p_one_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ahi_en_n_o, ~alo_en_n_o, ~din_en_n_o, ~dout_en_n_o}) <= 1);

  p_alo_after_ahi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alo_en_n_o) |-> $past(!ahi_en_n_o));

  p_din_after_alo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(din_en_n_o) |-> $past(!alo_en_n_o));

  p_dout_after_alo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_en_n_o) |-> $past(!alo_en_n_o));

  p_dout_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({dout_hi_o, dout_lo_o}) |-> $fell(dout_en_n_o));

endmodule

bind mbus_mem_emu mbus_mem_emu_chk #(.LO_BITS(LO_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ahi_en_n_o  (ahi_en_n_o),
  .alo_en_n_o  (alo_en_n_o),
  .din_en_n_o  (din_en_n_o),
  .dout_en_n_o (dout_en_n_o),
  .dout_lo_o   (dout_lo_o),
  .dout_hi_o   (dout_hi_o)
);

// File: tb/mbus_mem_emu_bench.sv
`timescale 1ns/1ps
module mbus_mem_emu_bench;

  localparam int SETTLE  = 5;
  localparam int AW      = 11;
  localparam int LO_BITS = 6;
  localparam int NVEC    = 8;

  // vector: {rw, addr[15:0], data[7:0]}; rw=1 read (data = expected)
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 16'h0010, 8'h11},
    {1'b0, 16'h0811, 8'h22},
    {1'b1, 16'h0010, 8'h11},
    {1'b1, 16'hF811, 8'h22},
    {1'b0, 16'h07FF, 8'hA5},
    {1'b1, 16'hFFFF, 8'hA5},
    {1'b0, 16'h0000, 8'h5A},
    {1'b1, 16'h8000, 8'h5A}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_clk, cpu_rw;
  logic [7:0] bus;
  logic ahi_n, alo_n, din_n, dout_n;
  logic [LO_BITS-1:0] dlo;
  logic [7-LO_BITS:0] dhi;
  logic host_we;
  logic [AW-1:0] host_addr;
  logic [7:0] host_wdata, host_rdata;

  logic [15:0] cur_addr;
  logic [7:0]  cur_wdata;

  int checks = 0;
  int errors = 0;
  int multi_en = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // transceiver model
  assign bus = !ahi_n ? cur_addr[15:8] :
               !alo_n ? cur_addr[7:0]  :
               !din_n ? cur_wdata      : 8'hEE;

  mbus_mem_emu #(.SETTLE(SETTLE), .MEM_AW(AW), .LO_BITS(LO_BITS)) u_mbus_mem_emu (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_clk_i    (cpu_clk),
    .cpu_rw_i     (cpu_rw),
    .bus_i        (bus),
    .ahi_en_n_o   (ahi_n),
    .alo_en_n_o   (alo_n),
    .din_en_n_o   (din_n),
    .dout_en_n_o  (dout_n),
    .dout_lo_o    (dlo),
    .dout_hi_o    (dhi),
    .host_we_i    (host_we),
    .host_addr_i  (host_addr),
    .host_wdata_i (host_wdata),
    .host_rdata_o (host_rdata)
  );

  always @(negedge clk) begin
    if (rst_n && ((!ahi_n) + (!alo_n) + (!din_n) + (!dout_n)) > 1) multi_en++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic wait_low(input string req, ref logic sig);
    int n = 0;
    while (sig !== 1'b0 && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(req, {31'd0, sig}, 32'd0);
  endtask

  task automatic cpu_cycle(input logic rw, input logic [15:0] a, input logic [7:0] d,
                           input bit collide, input logic [7:0] hd, input string tag);
    int alo_len;
    logic [7:0] held;
    cur_addr = a; cur_wdata = d; cpu_rw = rw;
    @(negedge clk);
    cpu_clk = 1'b0;
    wait_low({"R2 ahi enable ", tag}, ahi_n);
    chk({"R2 only ahi ", tag}, {29'd0, alo_n, din_n, dout_n}, 32'h7);
    repeat (SETTLE + 3) @(negedge clk);
    cpu_clk = 1'b1;
    wait_low({"R3 alo enable ", tag}, alo_n);
    alo_len = 0;
    while (alo_n === 1'b0 && alo_len < 60) begin
      alo_len++;
      @(negedge clk);
    end
    if (rw) begin
      chk({"R4 alo span read ", tag}, alo_len, SETTLE + 2);
      chk({"R6 dout enabled ", tag}, {31'd0, dout_n}, 32'd0);
      chk({"R6 R5 read data ", tag}, {24'd0, dhi, dlo}, {24'd0, d});
      repeat (4) @(negedge clk);
      chk({"R6 data held ", tag}, {23'd0, dout_n, dhi, dlo}, {24'd0, d});
    end else begin
      chk({"R4 alo span write ", tag}, alo_len, SETTLE);
      chk({"R7 din enabled ", tag}, {31'd0, din_n}, 32'd0);
      held = {dhi, dlo};
      if (collide) begin
        repeat (SETTLE - 1) @(negedge clk);
        host_addr = a[AW-1:0]; host_wdata = hd; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        repeat (3) @(negedge clk);
      end else begin
        repeat (SETTLE + 3) @(negedge clk);
      end
      chk({"R9 dout unchanged by write ", tag}, {24'd0, dhi, dlo}, {24'd0, held});
    end
  endtask

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; cpu_clk = 1'b1; cpu_rw = 1'b1;
    host_we = 1'b0; host_addr = '0; host_wdata = '0;
    cur_addr = '0; cur_wdata = '0;
    repeat (5) @(negedge clk);
    chk("R1 enables in reset", {28'd0, ahi_n, alo_n, din_n, dout_n}, 32'hF);
    chk("R1 dout in reset", {24'd0, dhi, dlo}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      cpu_cycle(VEC[i][24], VEC[i][23:8], VEC[i][7:0], 1'b0, 8'h00, $sformatf("vec%0d", i));
    end

    // host preload then CPU read through an alias
    host_write(11'h123, 8'hC3);
    host_read(11'h123, rd);
    chk("R10 host readback", {24'd0, rd}, 32'hC3);
    cpu_cycle(1'b1, 16'hA123, 8'hC3, 1'b0, 8'h00, "host preload");

    // CPU write then host read back
    cpu_cycle(1'b0, 16'h3456, 8'h96, 1'b0, 8'h00, "cpu wr");
    host_read(11'h456, rd);
    chk("R7 R5 host sees cpu write", {24'd0, rd}, 32'h96);

    // collision: host wins
    cpu_cycle(1'b0, 16'h0077, 8'h3C, 1'b1, 8'hA5, "collide");
    host_read(11'h077, rd);
    chk("R11 host wins collision", {24'd0, rd}, 32'hA5);

    chk("R8 single enable", multi_en, 0);

    // reset while an enable is active
    @(negedge clk);
    cpu_clk = 1'b0;
    wait_low("R2 ahi before reset", ahi_n);
    #3 rst_n = 1'b0;
    #2;
    chk("R1 enables drop in reset", {28'd0, ahi_n, alo_n, din_n, dout_n}, 32'hF);
    chk("R1 dout cleared", {24'd0, dhi, dlo}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule